// File: doc/BRIEF.md
# Boost Converter Enable Supervisor

This block holds the digital enable state of a boost pre-regulator inside a supply-management chip. It takes comparator and status bits from the analog side and decides, each cycle, whether the power switch may run. Those bits are the switch-node level seen at power-up, the output-versus-input difference comparator, boost undervoltage, switch over-temperature, ground loss and battery above the regulation target. It also takes the software enable bit. It publishes registered status bits for software and a request for the shared fault pin.

A strap is taken from the switch-node level on the first clock after reset is released. A low level means no inductor path to the battery, and the converter is then vetoed until the next reset. An over-temperature event latches the switch off until software reads the thermal flag. That read is given as a one-cycle pulse, and it clears the latch only once the fault has gone away. Ground loss and a high battery stop the switch only while they last. Undervoltage is reported only while the converter is enabled.

Top module: `boost_enable_supervisor`

## Requirements
- R1: While `rst` is high, every output reads 0.
- R2: If `sw_node_hi` is 0 on the first rising edge with `rst` low, `st_kept_off` becomes 1 after that edge. `switch_en` then stays 0 until the next reset, whatever `sw_node_hi` or `sw_en_reg` do later.
- R3: If `sw_node_hi` is 1 on that edge, `st_kept_off` stays 0 and `switch_en` follows `sw_en_reg` when all other conditions allow it.
- R4: `switch_en` is 1 exactly when all of these hold: strap allowed, `sw_en_reg`=1, `ready_cmp`=1, no thermal latch, `therm_flt`=0, `gnd_loss`=0 and `batt_high`=0. It is combinational in the inputs.
- R5: `st_ready` equals `ready_cmp` delayed by one clock.
- R6: `therm_flt`=1 forces `switch_en` to 0 in the same cycle. After the next edge `st_therm` is 1, and it stays 1 after the fault input drops.
- R7: A `flag_rd` pulse clears the thermal latch at the next edge only if `therm_flt` is 0 in that cycle. A pulse while the fault is still present leaves the latch set.
- R8: `gnd_loss`=1 forces `switch_en` to 0. When it returns to 0, `switch_en` comes back at once with no read needed.
- R9: `batt_high`=1 forces `switch_en` to 0.
- R10: `st_on` equals `switch_en` delayed by one clock, so it is 0 whenever the switch is off for a diagnostic or a high battery.
- R11: `st_uv` and `fault_req` equal, one clock later, `uv_cmp` AND strap allowed AND `sw_en_reg`.
- R12: Between the release of reset and the first rising edge that samples the strap, `switch_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| sw_node_hi | input | 1 | Switch-node level comparator, used as the power-up strap |
| ready_cmp | input | 1 | 1 when output is at or above the input-difference disable threshold |
| uv_cmp | input | 1 | Boost output undervoltage comparator |
| therm_flt | input | 1 | Switch over-temperature detector |
| gnd_loss | input | 1 | Boost ground loss detector |
| batt_high | input | 1 | Battery above the regulation target |
| sw_en_reg | input | 1 | Software enable bit from the control register |
| flag_rd | input | 1 | One-cycle pulse when software reads the thermal flag |
| switch_en | output | 1 | Power-switch enable |
| st_kept_off | output | 1 | Status: converter vetoed by strap |
| st_ready | output | 1 | Status: registered comparator ready |
| st_on | output | 1 | Status: switch was running last cycle |
| st_uv | output | 1 | Status: undervoltage while enabled |
| st_therm | output | 1 | Status: thermal latch set |
| fault_req | output | 1 | Request to the shared fault pin |

## Verification
Every cycle, the assertions check the following. The switch stays off under a strap veto, thermal fault, ground loss, high battery or low comparator. The kept-off and thermal latches hold, and a thermal fault sets the latch. The on and ready status bits track their sources one cycle late. Other behaviour is shown only by the bench scenarios. These cover the strap being taken on exactly the first edge after reset, the switch returning after ground loss, and the refusal to clear on a read while the fault persists. A sweep over all combinations of the enable conditions shows that no single combination enables the switch wrongly.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

    typedef struct packed {
        logic sw_req;
        logic ready;
        logic therm_now;
        logic therm_lat;
        logic gnd_loss;
        logic batt_high;
    } bsup_cond_t;

    typedef struct packed {
        logic kept_off;
        logic ready;
        logic on;
        logic uv;
        logic therm;
    } bsup_status_t;

    localparam int STATUS_W = $bits(bsup_status_t);

    function automatic logic bsup_enable(input logic allowed, input bsup_cond_t c);
        return allowed & c.sw_req & c.ready & ~c.therm_now & ~c.therm_lat
               & ~c.gnd_loss & ~c.batt_high;
    endfunction

endpackage

// File: rtl/bsup_strap_sampler.sv
module bsup_strap_sampler (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic taken,
    output logic allowed
);
    logic taken_q, level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            level_q <= 1'b0;
        end else if (!taken_q) begin
            taken_q <= 1'b1;
            level_q <= level;
        end
    end

    assign taken   = taken_q;
    assign allowed = taken_q & level_q;
endmodule

// File: rtl/bsup_therm_latch.sv
module bsup_therm_latch (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic rd_clr,
    output logic latched
);
    logic lat_q;

    // Set has priority: a read while the fault persists leaves the latch set.
    always_ff @(posedge clk) begin
        if (rst)         lat_q <= 1'b0;
        else if (fault)  lat_q <= 1'b1;
        else if (rd_clr) lat_q <= 1'b0;
    end

    assign latched = lat_q;
endmodule

// File: rtl/bsup_status_reg.sv
module bsup_status_reg
    import bsup_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bsup_status_t next,
    output bsup_status_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= next;
    end
endmodule

// File: rtl/boost_enable_supervisor.sv
module boost_enable_supervisor
    import bsup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_node_hi,
    input  logic ready_cmp,
    input  logic uv_cmp,
    input  logic therm_flt,
    input  logic gnd_loss,
    input  logic batt_high,
    input  logic sw_en_reg,
    input  logic flag_rd,
    output logic switch_en,
    output logic st_kept_off,
    output logic st_ready,
    output logic st_on,
    output logic st_uv,
    output logic st_therm,
    output logic fault_req
);
    logic         strap_taken, strap_ok, therm_lat, en_c;
    bsup_cond_t   cond;
    bsup_status_t stat_nx, stat_q;

    bsup_strap_sampler i_strap (
        .clk(clk), .rst(rst), .level(sw_node_hi),
        .taken(strap_taken), .allowed(strap_ok)
    );

    bsup_therm_latch i_therm (
        .clk(clk), .rst(rst), .fault(therm_flt), .rd_clr(flag_rd),
        .latched(therm_lat)
    );

    always_comb begin
        cond.sw_req    = sw_en_reg;
        cond.ready     = ready_cmp;
        cond.therm_now = therm_flt;
        cond.therm_lat = therm_lat;
        cond.gnd_loss  = gnd_loss;
        cond.batt_high = batt_high;
        en_c           = bsup_enable(strap_ok, cond) & ~rst;
    end

    always_comb begin
        stat_nx.kept_off = 1'b0;
        stat_nx.ready    = ready_cmp;
        stat_nx.on       = en_c;
        stat_nx.uv       = uv_cmp & strap_ok & sw_en_reg;
        stat_nx.therm    = 1'b0;
    end

    bsup_status_reg i_stat (
        .clk(clk), .rst(rst), .next(stat_nx), .cur(stat_q)
    );

    assign switch_en   = en_c;
    assign st_kept_off = strap_taken & ~strap_ok;
    assign st_ready    = stat_q.ready;
    assign st_on       = stat_q.on;
    assign st_uv       = stat_q.uv;
    assign st_therm    = therm_lat;
    assign fault_req   = stat_q.uv;
endmodule

// File: rtl/bsup_checker.sv
module bsup_checker (
    input logic clk,
    input logic rst,
    input logic ready_cmp,
    input logic therm_flt,
    input logic gnd_loss,
    input logic batt_high,
    input logic flag_rd,
    input logic switch_en,
    input logic st_kept_off,
    input logic st_ready,
    input logic st_on,
    input logic st_therm
);
    // R2
    veto_off_chk: assert property (@(posedge clk) disable iff (rst)
        st_kept_off |-> !switch_en);
    // R2
    veto_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st_kept_off |=> st_kept_off);
    // R4
    not_ready_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_cmp |-> !switch_en);
    // R5
    ready_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ready_cmp |=> st_ready);
    // R6
    therm_off_chk: assert property (@(posedge clk) disable iff (rst)
        therm_flt |-> !switch_en);
    // R6
    therm_set_chk: assert property (@(posedge clk) disable iff (rst)
        therm_flt |=> st_therm);
    // R7
    therm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_therm && !flag_rd) |=> st_therm);
    // R8
    gnd_off_chk: assert property (@(posedge clk) disable iff (rst)
        gnd_loss |-> !switch_en);
    // R9
    batt_off_chk: assert property (@(posedge clk) disable iff (rst)
        batt_high |-> !switch_en);
    // R10
    on_copy_chk: assert property (@(posedge clk) disable iff (rst)
        switch_en |=> st_on);
endmodule

bind boost_enable_supervisor bsup_checker i_chk (
    .clk(clk), .rst(rst), .ready_cmp(ready_cmp), .therm_flt(therm_flt),
    .gnd_loss(gnd_loss), .batt_high(batt_high), .flag_rd(flag_rd),
    .switch_en(switch_en), .st_kept_off(st_kept_off), .st_ready(st_ready),
    .st_on(st_on), .st_therm(st_therm)
);

// File: tb/test_boost_enable_supervisor.sv
module test_boost_enable_supervisor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_node_hi = 0, ready_cmp = 0, uv_cmp = 0, therm_flt = 0;
    logic gnd_loss = 0, batt_high = 0, sw_en_reg = 0, flag_rd = 0;
    logic switch_en, st_kept_off, st_ready, st_on, st_uv, st_therm, fault_req;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    boost_enable_supervisor i_boost_enable_supervisor (
        .clk(clk), .rst(rst), .sw_node_hi(sw_node_hi), .ready_cmp(ready_cmp),
        .uv_cmp(uv_cmp), .therm_flt(therm_flt), .gnd_loss(gnd_loss),
        .batt_high(batt_high), .sw_en_reg(sw_en_reg), .flag_rd(flag_rd),
        .switch_en(switch_en), .st_kept_off(st_kept_off), .st_ready(st_ready),
        .st_on(st_on), .st_uv(st_uv), .st_therm(st_therm), .fault_req(fault_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1;
        sw_node_hi = strap;
        therm_flt = 0; gnd_loss = 0; batt_high = 0; flag_rd = 0;
        step();
        step();
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: outputs low during reset even with every input high
        sw_node_hi = 1; ready_cmp = 1; uv_cmp = 1; sw_en_reg = 1;
        step();
        step();
        chk("R1 switch_en", switch_en, 0);
        chk("R1 kept_off", st_kept_off, 0);
        chk("R1 ready", st_ready, 0);
        chk("R1 on", st_on, 0);
        chk("R1 uv", st_uv, 0);
        chk("R1 therm", st_therm, 0);
        chk("R1 fault_req", fault_req, 0);

        // R2 and R12: strap low
        do_reset(1'b0);
        chk("R12 before strap edge", switch_en, 0);
        step();
        chk("R2 kept_off set", st_kept_off, 1);
        chk("R2 switch off", switch_en, 0);
        sw_node_hi = 1;
        for (int k = 0; k < 4; k++) begin
            sw_en_reg = k[0];
            step();
            chk("R2 veto persists", switch_en, 0);
            chk("R2 kept_off persists", st_kept_off, 1);
            chk("R11 uv masked under veto", st_uv, 0);
        end

        // R3 and R12: strap high
        sw_en_reg = 1; uv_cmp = 0;
        do_reset(1'b1);
        chk("R12 before strap edge", switch_en, 0);
        step();
        chk("R3 kept_off clear", st_kept_off, 0);
        chk("R3 enabled", switch_en, 1);
        sw_en_reg = 0; #1;
        chk("R3 software off", switch_en, 0);
        sw_en_reg = 1; #1;
        chk("R3 software on", switch_en, 1);
        sw_node_hi = 0;
        step();
        chk("R3 strap not resampled", switch_en, 1);

        // R4 R5 R8 R9 R10 R11: sweep of the enable conditions
        for (int v = 0; v < 32; v++) begin
            logic e_en, e_uv;
            {sw_en_reg, ready_cmp, gnd_loss, batt_high, uv_cmp} = v[4:0];
            e_en = v[4] & v[3] & ~v[2] & ~v[1];
            e_uv = v[0] & v[4];
            #1;
            chk("R4 enable equation", switch_en, e_en);
            step();
            chk("R5 ready status", st_ready, v[3]);
            chk("R10 on status", st_on, e_en);
            chk("R11 uv status", st_uv, e_uv);
            chk("R11 fault request", fault_req, e_uv);
        end

        // R6 R7: thermal latch
        sw_en_reg = 1; ready_cmp = 1; gnd_loss = 0; batt_high = 0; uv_cmp = 0;
        step();
        chk("R6 precondition on", switch_en, 1);
        therm_flt = 1; #1;
        chk("R6 off same cycle", switch_en, 0);
        step();
        chk("R6 flag set", st_therm, 1);
        therm_flt = 0;
        step();
        chk("R6 stays latched", st_therm, 1);
        chk("R6 switch stays off", switch_en, 0);
        therm_flt = 1; flag_rd = 1;
        step();
        flag_rd = 0; therm_flt = 0;
        chk("R7 read ignored while fault", st_therm, 1);
        step();
        chk("R7 still latched", st_therm, 1);
        chk("R7 still off", switch_en, 0);
        flag_rd = 1;
        step();
        flag_rd = 0;
        chk("R7 read clears", st_therm, 0);
        chk("R7 switch back", switch_en, 1);

        // R8: ground loss auto recovery
        gnd_loss = 1; #1;
        chk("R8 off on loss", switch_en, 0);
        step();
        chk("R8 still off", switch_en, 0);
        chk("R10 on status cleared", st_on, 0);
        gnd_loss = 0; #1;
        chk("R8 auto return", switch_en, 1);
        chk("R8 no thermal flag", st_therm, 0);

        // R9: battery above target
        batt_high = 1; #1;
        chk("R9 off", switch_en, 0);
        step();
        chk("R10 on status cleared", st_on, 0);
        batt_high = 0; #1;
        chk("R9 back on", switch_en, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule